// File: doc/BRIEF.md
# Strap Latch and Power-Down Control

This block sits between the shared configuration pins of a clock generator and its frequency synthesis core. While the device comes up, five frequency-select strap pins are read as inputs. When the power-good input is seen high, their levels are captured into a held latch, and the pins are released to drive clock outputs. After that capture the same power-good pin serves only as an asynchronous active-low power-down request. Pulling it low gates the internal clocks at once. It then asks the PLL to stop, and after a programmable hold it asks the crystal oscillator to stop.

A configuration byte, owned by a neighbouring register block, selects where the active frequency code comes from: the latched straps or a software-written field. The same byte carries the global output tristate and the spread-spectrum enable. The latched straps are read back inverted for software. The PLL, the oscillator and the analog pads are modelled elsewhere.

Top module: `strap_pd_ctrl`

## Requirements
- R1: While `rst_n` is low, `pad_oe`, `clk_run`, `pll_pd` and `osc_stop` are 0, `freq_code` is 0 (strap source) and `strap_rb` is all ones.
- R2: `pwrgd_pd_n` passes through a two-flop synchroniser. On the third rising clock edge after it goes high, `strap_pin` is captured and every `pad_oe` bit becomes 1. Before that edge, `pad_oe` is 0 and a low level on the pin raises no power-down request.
- R3: After capture, changes on `strap_pin` and later rises of `pwrgd_pd_n` do not alter the latched value until `rst_n` is asserted again.
- R4: `strap_rb` is the bitwise inverse of the latched strap value.
- R5: After capture, `pwrgd_pd_n` low drops `clk_run` with no clock edge. `pll_pd` rises after the second clock edge that samples the pin low. On return high, `clk_run` rises at once and `pll_pd` clears after the second edge that samples it high.
- R6: `osc_stop` rises OSC_HOLD edges after `pll_pd`. It therefore rises no later than OSC_HOLD+2 edges after the pin goes low. It is never high without `pll_pd` and it clears together with `pll_pd`.
- R7: With `cfg_byte[3]`=0, `freq_code` is the latched strap value. With `cfg_byte[3]`=1, `freq_code` is {`cfg_byte[2]`, `cfg_byte[7:4]`}, with bit 2 as the MSB.
- R8: `out_hiz` follows `cfg_byte[0]` and `spread_en` follows `cfg_byte[1]`.
- R9: A low pulse on `pwrgd_pd_n` that falls and rises between two rising edges drops `clk_run` only for its duration and raises neither `pll_pd` nor `osc_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| strap_pin | input | 5 | Strap levels on the shared pins |
| pwrgd_pd_n | input | 1 | Power-good strobe, then active-low power-down |
| cfg_byte | input | 8 | Control byte: [0] tristate, [1] spread, [3] source, {[2],[7:4]} code |
| freq_code | output | 5 | Active frequency select code |
| strap_rb | output | 5 | Inverted latched straps for readback |
| pad_oe | output | 5 | Output enable of each shared pin |
| clk_run | output | 1 | Internal clock enable, dropped asynchronously on power-down |
| pll_pd | output | 1 | Power-down request to the PLL |
| osc_stop | output | 1 | Stop request to the oscillator |
| out_hiz | output | 1 | Global output tristate |
| spread_en | output | 1 | Spread-spectrum modulation enable |

## Verification
The bench builds the block with OSC_HOLD set to 4 instead of the default 48. This keeps the oscillator-stop edge a handful of cycles away, so both the cycle before it and the cycle of it can be sampled. The latency checker uses the same value, so the full power-down bound is checked within each entry. Strap patterns with asymmetric bits make an inverted or reordered readback visible. A second reset with different straps shows that a fresh capture happens only after reset.

// File: rtl/strap_pd_ctrl.sv
module strap_pd_ctrl #(
  parameter int OSC_HOLD = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] strap_pin,
  input  logic       pwrgd_pd_n,
  input  logic [7:0] cfg_byte,
  output logic [4:0] freq_code,
  output logic [4:0] strap_rb,
  output logic [4:0] pad_oe,
  output logic       clk_run,
  output logic       pll_pd,
  output logic       osc_stop,
  output logic       out_hiz,
  output logic       spread_en
);
  localparam int FW = 5;
  localparam int CW = (OSC_HOLD > 0) ? $clog2(OSC_HOLD + 1) : 1;

  logic [1:0]    pg_sync;
  logic          pg_s;
  logic          latched;
  logic [FW-1:0] strap_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_sync <= '0;
    else        pg_sync <= {pg_sync[0], pwrgd_pd_n};
  end
  assign pg_s = pg_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      strap_q <= '0;
    end else if (pg_s && !latched) begin
      latched <= 1'b1;
      strap_q <= strap_pin;
    end
  end

  assign pll_pd = latched & ~pg_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hold_cnt <= '0;
    else if (!pll_pd)                    hold_cnt <= '0;
    else if (hold_cnt != CW'(OSC_HOLD))  hold_cnt <= hold_cnt + CW'(1);
  end

  assign osc_stop  = pll_pd & (hold_cnt == CW'(OSC_HOLD));
  assign clk_run   = latched & pwrgd_pd_n;
  assign pad_oe    = {FW{latched}};
  assign strap_rb  = ~strap_q;
  assign freq_code = cfg_byte[3] ? {cfg_byte[2], cfg_byte[7:4]} : strap_q;
  assign out_hiz   = cfg_byte[0];
  assign spread_en = cfg_byte[1];
endmodule

module strap_pd_ctrl_chk #(
  parameter int OSC_HOLD = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrgd_pd_n,
  input logic [4:0] pad_oe,
  input logic [4:0] strap_rb,
  input logic       clk_run,
  input logic       pll_pd,
  input logic       osc_stop
);
  localparam int PD_LIMIT = OSC_HOLD + 2;
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= 0;
    else if (pad_oe[0] && !pwrgd_pd_n) begin
      if (low_cnt < PD_LIMIT) low_cnt <= low_cnt + 1;
    end else low_cnt <= 0;
  end

  p_oe_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == 5'b00000) || (pad_oe == 5'b11111));

  p_idle_before_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == 5'b00000) |-> (!clk_run && !pll_pd));

  p_rb_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[0] && $past(pad_oe[0])) |-> $stable(strap_rb));

  p_pd_from_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pd |-> ($past(pwrgd_pd_n, 2) == 1'b0));

  p_osc_needs_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> pll_pd);

  p_pd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt >= PD_LIMIT) |-> osc_stop);
endmodule

bind strap_pd_ctrl strap_pd_ctrl_chk #(.OSC_HOLD(OSC_HOLD)) u_chk (.*);

// File: tb/tb_strap_pd_ctrl.sv
module tb_strap_pd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] strap_pin;
  logic       pwrgd_pd_n;
  logic [7:0] cfg_byte;
  logic [4:0] freq_code, strap_rb, pad_oe;
  logic       clk_run, pll_pd, osc_stop, out_hiz, spread_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [19:0] exp_q[$];
  string       req_q[$];
  event        ev_sample;

  strap_pd_ctrl #(.OSC_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .strap_pin(strap_pin), .pwrgd_pd_n(pwrgd_pd_n),
    .cfg_byte(cfg_byte), .freq_code(freq_code), .strap_rb(strap_rb),
    .pad_oe(pad_oe), .clk_run(clk_run), .pll_pd(pll_pd), .osc_stop(osc_stop),
    .out_hiz(out_hiz), .spread_en(spread_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [19:0] mk(input logic [4:0] fc, input logic [4:0] rb,
    input logic [4:0] oe, input logic run, input logic pd, input logic osc,
    input logic hiz, input logic spr);
    return {fc, rb, oe, run, pd, osc, hiz, spr};
  endfunction

  task automatic expect_now(input string req, input logic [19:0] e);
    exp_q.push_back(e);
    req_q.push_back(req);
    -> ev_sample;
    #0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(ev_sample);
      while (exp_q.size() > 0) begin
        logic [19:0] e, a;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        a = {freq_code, strap_rb, pad_oe, clk_run, pll_pd, osc_stop, out_hiz, spread_en};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", r, a, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwrgd_pd_n = 1'b0; strap_pin = 5'b10110; cfg_byte = 8'h00;
    tick(2);
    expect_now("R1 reset state", mk(5'b00000, 5'b11111, 5'b00000, 0, 0, 0, 0, 0));
    rst_n = 1'b1;
    tick(4);
    expect_now("R2 pin low before capture", mk(5'b00000, 5'b11111, 5'b00000, 0, 0, 0, 0, 0));
    pwrgd_pd_n = 1'b1;
    tick(2);
    expect_now("R2 not captured after two edges", mk(5'b00000, 5'b11111, 5'b00000, 0, 0, 0, 0, 0));
    tick(1);
    expect_now("R2 captured on third edge", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));
    strap_pin = 5'b01011;
    tick(3);
    expect_now("R3 strap change ignored", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));
    expect_now("R4 inverted readback", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));

    cfg_byte = 8'b1100_1100; #1;
    expect_now("R7 register source", mk(5'b11100, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));
    cfg_byte = 8'b1100_0100; #1;
    expect_now("R7 strap source", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));
    cfg_byte = 8'b0000_0011; #1;
    expect_now("R8 tristate and spread", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 1, 1));
    cfg_byte = 8'b0000_0000;
    tick(1);

    pwrgd_pd_n = 1'b0; strap_pin = 5'b00001; #1;
    expect_now("R5 clk_run drops at once", mk(5'b10110, 5'b01001, 5'b11111, 0, 0, 0, 0, 0));
    tick(1);
    expect_now("R5 no pll_pd after one edge", mk(5'b10110, 5'b01001, 5'b11111, 0, 0, 0, 0, 0));
    tick(1);
    expect_now("R5 pll_pd after two edges", mk(5'b10110, 5'b01001, 5'b11111, 0, 1, 0, 0, 0));
    tick(HOLD - 1);
    expect_now("R6 osc_stop one edge early", mk(5'b10110, 5'b01001, 5'b11111, 0, 1, 0, 0, 0));
    tick(1);
    expect_now("R6 osc_stop on time", mk(5'b10110, 5'b01001, 5'b11111, 0, 1, 1, 0, 0));
    tick(3);
    pwrgd_pd_n = 1'b1; #1;
    expect_now("R5 clk_run returns at once", mk(5'b10110, 5'b01001, 5'b11111, 1, 1, 1, 0, 0));
    tick(1);
    expect_now("R5 pll_pd held one edge", mk(5'b10110, 5'b01001, 5'b11111, 1, 1, 1, 0, 0));
    tick(1);
    expect_now("R6 release with pll_pd", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));
    tick(4);
    expect_now("R3 no recapture on rise", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));

    #2 pwrgd_pd_n = 1'b0; #1;
    expect_now("R9 glitch drops clk_run", mk(5'b10110, 5'b01001, 5'b11111, 0, 0, 0, 0, 0));
    #1 pwrgd_pd_n = 1'b1;
    tick(4);
    expect_now("R9 glitch no power-down", mk(5'b10110, 5'b01001, 5'b11111, 1, 0, 0, 0, 0));

    rst_n = 1'b0; #1;
    expect_now("R1 reset while running", mk(5'b00000, 5'b11111, 5'b00000, 0, 0, 0, 0, 0));
    tick(1);
    rst_n = 1'b1;
    tick(3);
    expect_now("R2 recapture after reset", mk(5'b00001, 5'b11110, 5'b11111, 1, 0, 0, 0, 0));

    tick(1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule